// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of one read or write burst inside an already open SDRAM row. A controller pulses a start strobe with a starting column, a burst length code and an ordering flag. From the next clock on, the block presents one column per cycle and marks the final beat of a fixed-length burst with a done flag.

Addresses wrap inside the aligned block that the burst length defines. Sequential order adds the beat count to the low address bits. Interleaved order XORs the beat count into them. A full-page burst walks the whole row and wraps around until it is stopped. A running burst can be ended at once by a terminate strobe. It can be restarted on any cycle, either by an interrupt strobe that carries a new column and keeps the current mode, or by a fresh start that also loads a new mode.

Top module: `col_burst_gen`

## Requirements
- R1: After reset, beat_o and done_o are 0.
- R2: A start_i pulse sampled on a clock edge makes beat_o 1 and col_o equal to start_col_i right after that edge. Each following beat appears one edge later.
- R3: The length code values 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. In sequential order (interleave_i = 0), beat k has low log2(BL) bits equal to (start + k) mod BL, and its upper bits equal the start column's upper bits.
- R4: In interleaved order (interleave_i = 1) with codes 0 to 3, beat k has low log2(BL) bits equal to (start XOR k), and its upper bits equal the start column's upper bits.
- R5: done_o is 1 exactly during the last beat of a fixed-length burst. On the following edge beat_o drops to 0, unless a new start or interrupt arrives.
- R6: Length code 0 gives a single beat equal to the start column, with done_o set on that beat.
- R7: A length code with bit 2 set selects full page. Beats then step through all 256 columns, wrap from 255 to 0, never raise done_o, and continue until terminated or restarted.
- R8: With full page selected, interleave_i has no effect and the order is sequential.
- R9: A term_i pulse ends a running burst, so beat_o and done_o are 0 after that edge. When the block is idle, term_i has no effect.
- R10: An intr_i pulse during a running burst restarts it from intr_col_i on the next beat. It keeps the running burst's length and order and ignores the current mode inputs. It wins over term_i.
- R11: start_i may arrive on any cycle, including back to back and in the middle of a burst. It restarts with the newly given column and mode, and it wins over intr_i and term_i.
- R12: intr_i while idle has no effect: beat_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | 8 | First column of the new burst |
| bl_code_i | input | 3 | Length code: 0..3 give 1/2/4/8 beats, bit 2 set gives full page |
| interleave_i | input | 1 | 1 selects interleaved order |
| term_i | input | 1 | Stop the running burst |
| intr_i | input | 1 | Restart the running burst at a new column |
| intr_col_i | input | 8 | Column used by intr_i |
| col_o | output | 8 | Current column address |
| beat_o | output | 1 | col_o is a valid beat |
| done_o | output | 1 | Current beat is the last one |

## Verification
Every strobe is acted on at the edge that samples it. The first beat, an interrupt restart and a terminate all show on the outputs right after that edge, so each has a latency of one cycle. Beat k of an undisturbed burst is therefore due k+1 edges after the start. The bench drives inputs on the falling edge and checks outputs on the following falling edge, which sits half a cycle after the edge that produced them. It compares them there against columns computed from the add-and-mask or XOR-and-mask formula of the requirements.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;

    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd4
    } len_code_e;

    // A code with bit 2 set always means a full-page burst.
    function automatic logic is_page(input logic [2:0] code);
        return code[2];
    endfunction

endpackage

// File: rtl/col_len_dec.sv
module col_len_dec #(
    parameter int COL_W = 8
) (
    input  logic [2:0]       code_i,
    output logic             page_o,
    output logic [COL_W-1:0] mask_o
);
    import col_burst_pkg::*;

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    always_comb begin
        page_o = is_page(code_i);
        if (page_o) begin
            mask_o = '1;
        end else begin
            mask_o = (ONE << code_i[1:0]) - ONE;
        end
    end
endmodule

// File: rtl/col_addr_map.sv
module col_addr_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] low_seq;
    logic [COL_W-1:0] low_ilv;

    always_comb begin
        low_seq = (base_i + cnt_i) & mask_i;
        low_ilv = (base_i ^ cnt_i) & mask_i;
        col_o   = (base_i & ~mask_i) | (ilv_i ? low_ilv : low_seq);
    end
endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       bl_code_i,
    input  logic             interleave_i,
    input  logic             term_i,
    input  logic             intr_i,
    input  logic [COL_W-1:0] intr_col_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_o,
    output logic             done_o
);
    typedef struct packed {
        logic             active;
        logic             ilv;
        logic             page;
        logic [COL_W-1:0] base;
        logic [COL_W-1:0] cnt;
        logic [COL_W-1:0] mask;
    } burst_st_t;

    burst_st_t st_d, st_q;

    logic             new_page;
    logic [COL_W-1:0] new_mask;
    logic             last_beat;

    col_len_dec #(.COL_W(COL_W)) u_dec (
        .code_i (bl_code_i),
        .page_o (new_page),
        .mask_o (new_mask)
    );

    col_addr_map #(.COL_W(COL_W)) u_map (
        .base_i (st_q.base),
        .cnt_i  (st_q.cnt),
        .mask_i (st_q.mask),
        .ilv_i  (st_q.ilv),
        .col_o  (col_o)
    );

    assign last_beat = st_q.active && !st_q.page && (st_q.cnt == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.base   = start_col_i;
            st_d.cnt    = '0;
            st_d.mask   = new_mask;
            st_d.page   = new_page;
            st_d.ilv    = interleave_i && !new_page;
        end else if (intr_i && st_q.active) begin
            st_d.base   = intr_col_i;
            st_d.cnt    = '0;
        end else if (term_i) begin
            st_d.active = 1'b0;
        end else if (st_q.active) begin
            if (last_beat) begin
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + COL_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_o = st_q.active;
    assign done_o = last_beat;
endmodule

// File: rtl/col_burst_chk.sv
module col_burst_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             term_i,
    input logic             intr_i,
    input logic [COL_W-1:0] intr_col_i,
    input logic [COL_W-1:0] col_o,
    input logic             beat_o,
    input logic             done_o
);
    // R2
    start_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> beat_o && col_o == $past(start_col_i));

    // R10
    intr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        intr_i && beat_o && !start_i |=> beat_o && col_o == $past(intr_col_i));

    // R9
    term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_i && !start_i && !(intr_i && beat_o) |=> !beat_o && !done_o);

    // R5
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !start_i && !intr_i |=> !beat_o);

    // R5
    done_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> beat_o);

    // R12
    idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_o && !start_i |=> !beat_o);
endmodule

bind col_burst_gen col_burst_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_col_burst_gen.sv
`timescale 1ns/1ps
module tb_col_burst_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] bl_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       term_i = 1'b0;
    logic       intr_i = 1'b0;
    logic [7:0] intr_col_i = '0;
    logic [7:0] col_o;
    logic       beat_o;
    logic       done_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    col_burst_gen dut (.*);

    function automatic logic [7:0] exp_col(input logic [7:0] s, input int code,
                                           input bit ilv, input int k);
        logic [7:0] m;
        if (code >= 4) return 8'(s + k);
        m = 8'((1 << code) - 1);
        if (ilv) return (s & ~m) | ((s ^ 8'(k)) & m);
        return (s & ~m) | (8'(s + k) & m);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check one output beat: column, valid and done flags.
    task automatic chk_beat(input string req, input logic [7:0] c, input bit d);
        chk(beat_o == 1'b1, req, beat_o, 1);
        chk(col_o == c, req, col_o, c);
        chk(done_o == d, req, done_o, d);
    endtask

    task automatic pulse_start(input logic [7:0] c, input int code, input bit ilv);
        start_i = 1'b1; start_col_i = c; bl_code_i = 3'(code); interleave_i = ilv;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_fixed(input string req, input logic [7:0] s, input int code, input bit ilv);
        int len = 1 << code;
        pulse_start(s, code, ilv);
        for (int k = 0; k < len; k++) begin
            chk_beat(req, exp_col(s, code, ilv, k), k == len - 1);
            @(negedge clk);
        end
        chk(beat_o == 1'b0, req, beat_o, 0);
    endtask

    task automatic t_reset();
        chk(beat_o == 1'b0, "R1", beat_o, 0);
        chk(done_o == 1'b0, "R1", done_o, 0);
    endtask

    task automatic t_sequential();
        run_fixed("R3", 8'h3D, 3, 1'b0);
        run_fixed("R3", 8'h81, 1, 1'b0);
        run_fixed("R3", 8'hC6, 2, 1'b0);
    endtask

    task automatic t_interleaved();
        run_fixed("R4", 8'h5B, 3, 1'b1);
        run_fixed("R4", 8'h12, 2, 1'b1);
    endtask

    task automatic t_single();
        run_fixed("R6", 8'hA7, 0, 1'b0);
        run_fixed("R6", 8'h42, 0, 1'b1);
    endtask

    task automatic t_full_page(input bit ilv);
        pulse_start(8'hFA, 4, ilv);
        for (int k = 0; k < 12; k++) begin
            chk_beat(ilv ? "R8" : "R7", exp_col(8'hFA, 4, 1'b0, k), 1'b0);
            @(negedge clk);
        end
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk(beat_o == 1'b0, "R9", beat_o, 0);
    endtask

    task automatic t_terminate();
        pulse_start(8'h10, 3, 1'b0);
        chk_beat("R9", 8'h10, 1'b0);
        @(negedge clk);
        chk_beat("R9", 8'h11, 1'b0);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk(beat_o == 1'b0, "R9", beat_o, 0);
        chk(done_o == 1'b0, "R9", done_o, 0);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk(beat_o == 1'b0, "R9 idle", beat_o, 0);
    endtask

    task automatic t_interrupt();
        logic [7:0] seq [4] = '{8'h2A, 8'h2B, 8'h28, 8'h29};
        pulse_start(8'h05, 2, 1'b1);
        chk_beat("R10", 8'h05, 1'b0);
        intr_i = 1'b1; intr_col_i = 8'h2A; term_i = 1'b1;
        bl_code_i = 3'd3; interleave_i = 1'b0;
        @(negedge clk);
        intr_i = 1'b0; term_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk_beat("R10", seq[k], k == 3);
            @(negedge clk);
        end
        chk(beat_o == 1'b0, "R10", beat_o, 0);
    endtask

    task automatic t_restart();
        start_i = 1'b1; start_col_i = 8'h70; bl_code_i = 3'd3; interleave_i = 1'b0;
        @(negedge clk);
        chk_beat("R11", 8'h70, 1'b0);
        start_col_i = 8'h93; bl_code_i = 3'd1; interleave_i = 1'b1; intr_i = 1'b1;
        intr_col_i = 8'h00;
        @(negedge clk);
        start_i = 1'b0; intr_i = 1'b0;
        chk_beat("R11", 8'h93, 1'b0);
        @(negedge clk);
        chk_beat("R11", 8'h92, 1'b1);
        @(negedge clk);
        chk(beat_o == 1'b0, "R11", beat_o, 0);
    endtask

    task automatic t_idle_intr();
        intr_i = 1'b1; intr_col_i = 8'h55;
        @(negedge clk);
        intr_i = 1'b0;
        chk(beat_o == 1'b0, "R12", beat_o, 0);
        @(negedge clk);
        chk(beat_o == 1'b0, "R12", beat_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sequential();
        t_interleaved();
        t_single();
        t_full_page(1'b0);
        t_full_page(1'b1);
        t_terminate();
        t_interrupt();
        t_restart();
        t_idle_intr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule